// File: doc/BRIEF.md
# Dual-Timebase Capture/Compare Array

The block holds two 16-bit up-counting timebases, each paired with a reload register, and sixteen dual-purpose channel registers. Software binds every channel to one of the two timebases at run time and chooses per channel whether it records the time of an input edge (capture) or signals when the timebase reaches a programmed value (compare). A capture copies the bound timer into the channel register. A compare match toggles the channel's output pin. Either event raises that channel's request flag. The last four channels have no output pin and can only capture.

Each timebase advances on one of three kinds of tick, chosen by software: a power-of-two division of the system clock, a single-cycle overflow pulse from a neighbouring timer, or rising edges on an external count pin. Only the first timebase can use the count pin. All programming and readback go through a flat register port with a single-cycle write strobe and a combinational read path.

Top module: `ccu_dual_array`

## Requirements
- R1: After reset every register reads zero, all output pins are low and no request flag is set. Register map (6-bit address): 0..15 channel value; 16 timer A count; 17 timer A reload; 18 timer B count; 19 timer B reload; 20 timer A control; 21 timer B control; 24 request flags (bit n = channel n); 32..47 channel configuration.
- R2: On each tick a running timer adds one. On a tick at 0xFFFF it loads its reload value instead.
- R3: Timer control bits [2:0] select a tick every 2^(3+d) system clocks for d = 0..7, when the source field bits [4:3] is 00.
- R4: Source code 01 makes the timer tick once per system clock cycle in which `ext_ovf` is high.
- R5: Source code 10 makes timer A tick on each rising edge of `cnt_pin`. For timer B this code, like code 11, produces no ticks.
- R6: Timer control bit 5 clear holds the timer. Only a bus write then changes its count.
- R7: Channel configuration bits [1:0] = 01 selects capture. Bits [4:3] pick the trigger: bit 3 is a rising edge, bit 4 is a falling edge, and both set means either edge. On a trigger the channel latches its bound timer and sets its flag. A pin change is seen after a two-flop synchronizer and the capture lands on the third clock edge after the change.
- R8: Channel configuration bit 2 binds the channel to timer B when set and to timer A when clear, for both capture and compare.
- R9: Configuration bits [1:0] = 10 selects compare. Compare is evaluated only when the bound timer has counted. On the clock edge after the count step that brings the timer equal to the channel value, the channel's output pin toggles and its flag is set. Loading the timer through the bus never causes a match.
- R10: Channels 12..15 have no output pin. In compare mode they never set their flag.
- R11: Writing 1 to a flag bit clears it and writing 0 leaves it alone. A new event in the same cycle wins over the clear.
- R12: Configuration bits [1:0] = 00 disables the channel, so pin edges leave its value and flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| cc_pin_in | input | 16 | Channel capture inputs, asynchronous |
| ext_ovf | input | 1 | Overflow pulse from a neighbouring timer, synchronous |
| cnt_pin | input | 1 | External count input for timer A, asynchronous |
| cc_pin_out | output | 12 | Compare outputs of channels 0..11 |
| irq_flag | output | 16 | Per-channel request flags |

## Verification
The assertions assume that the bus never writes a timer count and its reload in the same cycle as a wrap-around they would race. They also assume that `ext_ovf` is a clean synchronous pulse. The bench keeps timers stopped or fed by single `ext_ovf` pulses whenever it reprograms them. It drives pin changes at least three cycles apart, so each edge passes the synchronizer alone. The prescaler is checked over windows that are a whole multiple of every division ratio, so the free-running divider phase never affects the expected count.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
    localparam int TMR_W   = 16;
    localparam int N_CHAN  = 16;
    localparam int N_OUT   = 12;
    localparam int ADDR_W  = 6;
    localparam int PRE_W   = 10;

    localparam logic [ADDR_W-1:0] A_TA_CNT = 6'd16;
    localparam logic [ADDR_W-1:0] A_TA_REL = 6'd17;
    localparam logic [ADDR_W-1:0] A_TB_CNT = 6'd18;
    localparam logic [ADDR_W-1:0] A_TB_REL = 6'd19;
    localparam logic [ADDR_W-1:0] A_TA_CTL = 6'd20;
    localparam logic [ADDR_W-1:0] A_TB_CTL = 6'd21;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 6'd24;
    localparam logic [ADDR_W-1:0] A_CFG0   = 6'd32;

    typedef enum logic [1:0] {
        SRC_PRESC  = 2'b00,
        SRC_EXTOVF = 2'b01,
        SRC_PIN    = 2'b10,
        SRC_NONE   = 2'b11
    } tick_src_e;

    typedef enum logic [1:0] {
        MD_OFF = 2'b00,
        MD_CAP = 2'b01,
        MD_CMP = 2'b10,
        MD_RSV = 2'b11
    } ch_mode_e;

    typedef struct packed {
        logic      run;
        tick_src_e src;
        logic [2:0] div;
    } tmr_ctl_t;

    typedef struct packed {
        logic [1:0] edg;
        logic       tsel;
        ch_mode_e   mode;
    } ch_cfg_t;

    function automatic logic presc_hit(input logic [PRE_W-1:0] cnt, input logic [2:0] div);
        logic [PRE_W-1:0] mask;
        mask = (PRE_W'(8) << div) - PRE_W'(1);
        return (cnt & mask) == '0;
    endfunction
endpackage

// File: rtl/ccu_sync.sv
module ccu_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] now_q,
    output logic [W-1:0] prev_q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            now_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_in;
            now_q  <= meta_q;
            prev_q <= now_q;
        end
    end
endmodule

// File: rtl/ccu_timebase.sv
module ccu_timebase
    import ccu_pkg::*;
#(
    parameter int TW      = 16,
    parameter int PW      = 10,
    parameter bit HAS_PIN = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  tmr_ctl_t      ctl,
    input  logic [PW-1:0] presc,
    input  logic          ext_ovf,
    input  logic          pin_rise,
    input  logic          wr_cnt,
    input  logic          wr_rel,
    input  logic [TW-1:0] wdata,
    output logic [TW-1:0] cnt,
    output logic [TW-1:0] rel,
    output logic          upd
);
    logic tick;

    always_comb begin
        unique case (ctl.src)
            SRC_PRESC:  tick = presc_hit(presc, ctl.div);
            SRC_EXTOVF: tick = ext_ovf;
            SRC_PIN:    tick = HAS_PIN ? pin_rise : 1'b0;
            default:    tick = 1'b0;
        endcase
        tick = tick & ctl.run;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            rel <= '0;
            upd <= 1'b0;
        end else begin
            upd <= 1'b0;
            if (wr_rel) rel <= wdata;
            if (wr_cnt) begin
                cnt <= wdata;
            end else if (tick) begin
                cnt <= (cnt == '1) ? rel : cnt + 1'b1;
                upd <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ccu_channel.sv
module ccu_channel
    import ccu_pkg::*;
#(
    parameter int TW      = 16,
    parameter bit HAS_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  ch_cfg_t       cfg,
    input  logic [TW-1:0] tm_a,
    input  logic [TW-1:0] tm_b,
    input  logic          upd_a,
    input  logic          upd_b,
    input  logic          pin_rise,
    input  logic          pin_fall,
    input  logic          wr_val,
    input  logic [TW-1:0] wdata,
    output logic [TW-1:0] val,
    output logic          cap_ev,
    output logic          cmp_ev
);
    logic [TW-1:0] tm_sel;
    logic          upd_sel;

    always_comb begin
        tm_sel  = cfg.tsel ? tm_b : tm_a;
        upd_sel = cfg.tsel ? upd_b : upd_a;
        cap_ev  = (cfg.mode == MD_CAP) &&
                  ((cfg.edg[0] && pin_rise) || (cfg.edg[1] && pin_fall));
        cmp_ev  = HAS_OUT && (cfg.mode == MD_CMP) && upd_sel && (tm_sel == val);
    end

    always_ff @(posedge clk) begin
        if (rst)          val <= '0;
        else if (cap_ev)  val <= tm_sel;
        else if (wr_val)  val <= wdata;
    end
endmodule

// File: rtl/ccu_dual_array.sv
module ccu_dual_array
    import ccu_pkg::*;
#(
    parameter int TW   = TMR_W,
    parameter int NCH  = N_CHAN,
    parameter int NOUT = N_OUT,
    parameter int AW   = ADDR_W,
    parameter int PW   = PRE_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [TW-1:0]   bus_wdata,
    output logic [TW-1:0]   bus_rdata,
    input  logic [NCH-1:0]  cc_pin_in,
    input  logic            ext_ovf,
    input  logic            cnt_pin,
    output logic [NOUT-1:0] cc_pin_out,
    output logic [NCH-1:0]  irq_flag
);
    localparam int CW = $bits(ch_cfg_t);
    localparam int KW = $bits(tmr_ctl_t);

    logic [PW-1:0]  presc_q;
    tmr_ctl_t       tctl [2];
    logic [TW-1:0]  tmr_cnt [2];
    logic [TW-1:0]  tmr_rel [2];
    logic [1:0]     tmr_upd;
    logic [1:0]     tmr_run;
    ch_cfg_t        ch_cfg [NCH];
    logic [TW-1:0]  ch_val [NCH];
    logic [NCH-1:0] cap_ev, cmp_ev;
    logic [NCH:0]   pin_now, pin_prev;
    logic [NCH:0]   pin_rise, pin_fall;
    logic           wr_flags;

    assign pin_rise = pin_now & ~pin_prev;
    assign pin_fall = ~pin_now & pin_prev;
    assign wr_flags = bus_we && (bus_addr == A_FLAGS);

    ccu_sync #(.W(NCH + 1)) u_sync (
        .clk(clk), .rst(rst), .async_in({cnt_pin, cc_pin_in}),
        .now_q(pin_now), .prev_q(pin_prev)
    );

    always_ff @(posedge clk) begin
        if (rst) presc_q <= '0;
        else     presc_q <= presc_q + 1'b1;
    end

    for (genvar t = 0; t < 2; t++) begin : g_tmr
        localparam logic [AW-1:0] CNT_A = AW'(A_TA_CNT + 2 * t);
        localparam logic [AW-1:0] CTL_A = AW'(A_TA_CTL + t);

        always_ff @(posedge clk) begin
            if (rst)                               tctl[t] <= '0;
            else if (bus_we && bus_addr == CTL_A)  tctl[t] <= tmr_ctl_t'(bus_wdata[KW-1:0]);
        end

        assign tmr_run[t] = tctl[t].run;

        ccu_timebase #(.TW(TW), .PW(PW), .HAS_PIN(t == 0)) u_tb (
            .clk(clk), .rst(rst), .ctl(tctl[t]), .presc(presc_q),
            .ext_ovf(ext_ovf), .pin_rise(pin_rise[NCH]),
            .wr_cnt(bus_we && bus_addr == CNT_A),
            .wr_rel(bus_we && bus_addr == CNT_A + 1'b1),
            .wdata(bus_wdata), .cnt(tmr_cnt[t]), .rel(tmr_rel[t]), .upd(tmr_upd[t])
        );
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)                                        ch_cfg[i] <= '0;
            else if (bus_we && bus_addr == AW'(A_CFG0 + i)) ch_cfg[i] <= ch_cfg_t'(bus_wdata[CW-1:0]);
        end

        ccu_channel #(.TW(TW), .HAS_OUT(i < NOUT)) u_ch (
            .clk(clk), .rst(rst), .cfg(ch_cfg[i]),
            .tm_a(tmr_cnt[0]), .tm_b(tmr_cnt[1]),
            .upd_a(tmr_upd[0]), .upd_b(tmr_upd[1]),
            .pin_rise(pin_rise[i]), .pin_fall(pin_fall[i]),
            .wr_val(bus_we && bus_addr == AW'(i)), .wdata(bus_wdata),
            .val(ch_val[i]), .cap_ev(cap_ev[i]), .cmp_ev(cmp_ev[i])
        );

        if (i < NOUT) begin : g_out
            always_ff @(posedge clk) begin
                if (rst)            cc_pin_out[i] <= 1'b0;
                else if (cmp_ev[i]) cc_pin_out[i] <= ~cc_pin_out[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq_flag <= '0;
        else     irq_flag <= (irq_flag & ~(wr_flags ? bus_wdata[NCH-1:0] : '0)) | cap_ev | cmp_ev;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr < AW'(NCH)) begin
            bus_rdata = ch_val[bus_addr[$clog2(NCH)-1:0]];
        end else if (bus_addr >= A_CFG0 && bus_addr < AW'(A_CFG0 + NCH)) begin
            bus_rdata = TW'(ch_cfg[bus_addr[$clog2(NCH)-1:0]]);
        end else begin
            case (bus_addr)
                A_TA_CNT: bus_rdata = tmr_cnt[0];
                A_TA_REL: bus_rdata = tmr_rel[0];
                A_TB_CNT: bus_rdata = tmr_cnt[1];
                A_TB_REL: bus_rdata = tmr_rel[1];
                A_TA_CTL: bus_rdata = TW'(tctl[0]);
                A_TB_CTL: bus_rdata = TW'(tctl[1]);
                A_FLAGS:  bus_rdata = TW'(irq_flag);
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ccu_checker.sv
module ccu_checker
    import ccu_pkg::*;
#(
    parameter int TW   = TMR_W,
    parameter int NCH  = N_CHAN,
    parameter int NOUT = N_OUT,
    parameter int AW   = ADDR_W
) (
    input logic            clk,
    input logic            rst,
    input logic            bus_we,
    input logic [AW-1:0]   bus_addr,
    input logic [TW-1:0]   bus_wdata,
    input logic [TW-1:0]   tmr_a,
    input logic [TW-1:0]   tmr_b,
    input logic [TW-1:0]   rel_a,
    input logic [TW-1:0]   rel_b,
    input logic [1:0]      run,
    input logic [NOUT-1:0] cc_pin_out,
    input logic [NCH-1:0]  irq_flag
);
    AST_STEP_A: assert property (@(posedge clk) disable iff (rst)
        (!$stable(tmr_a) && !$past(bus_we && bus_addr == A_TA_CNT)) |->
        ((tmr_a == $past(tmr_a) + 1'b1) || ($past(tmr_a) == '1 && tmr_a == $past(rel_a)))); // R2

    AST_STEP_B: assert property (@(posedge clk) disable iff (rst)
        (!$stable(tmr_b) && !$past(bus_we && bus_addr == A_TB_CNT)) |->
        ((tmr_b == $past(tmr_b) + 1'b1) || ($past(tmr_b) == '1 && tmr_b == $past(rel_b)))); // R2

    AST_HOLD_A: assert property (@(posedge clk) disable iff (rst)
        (!$past(run[0]) && !$past(bus_we && bus_addr == A_TA_CNT)) |-> $stable(tmr_a)); // R6

    AST_HOLD_B: assert property (@(posedge clk) disable iff (rst)
        (!$past(run[1]) && !$past(bus_we && bus_addr == A_TB_CNT)) |-> $stable(tmr_b)); // R6

    AST_TOGGLE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        !$stable(cc_pin_out) |->
        (((cc_pin_out ^ $past(cc_pin_out)) & ~irq_flag[NOUT-1:0]) == '0)); // R9

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (($past(irq_flag) & ~irq_flag &
          ~($past(bus_we && bus_addr == A_FLAGS) ? $past(bus_wdata[NCH-1:0]) : '0)) == '0)); // R11
endmodule

bind ccu_dual_array ccu_checker #(.TW(TW), .NCH(NCH), .NOUT(NOUT), .AW(AW)) u_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .tmr_a(tmr_cnt[0]), .tmr_b(tmr_cnt[1]), .rel_a(tmr_rel[0]), .rel_b(tmr_rel[1]),
    .run(tmr_run), .cc_pin_out(cc_pin_out), .irq_flag(irq_flag)
);

// File: tb/sim_ccu_dual_array.sv
module sim_ccu_dual_array;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] cc_pin_in = '0;
    logic        ext_ovf = 1'b0;
    logic        cnt_pin = 1'b0;
    logic [11:0] cc_pin_out;
    logic [15:0] irq_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    ccu_dual_array u0 (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cc_pin_in(cc_pin_in), .ext_ovf(ext_ovf), .cnt_pin(cnt_pin),
        .cc_pin_out(cc_pin_out), .irq_flag(irq_flag)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse_ovf();
        @(negedge clk); ext_ovf = 1'b1;
        @(negedge clk); ext_ovf = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d, c0, ca, cb, ra, rb;
        logic [11:0] exp_out;
        logic [15:0] exp_flg, pins_old, tva, tvb;
        logic [15:0] exp_val [16];
        logic [15:0] pat [6];

        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state over the whole register map
        for (int a = 0; a < 48; a++) begin
            if (a < 22 || a == 24 || a >= 32) begin
                rd(6'(a), d);
                chk("R1", d, 16'h0000);
            end
        end
        chk("R1", {4'h0, cc_pin_out}, 16'h0000);
        chk("R1", irq_flag, 16'h0000);

        // R2 R4 R8 R9 R10: step both timers with ext_ovf, compare on both timebases
        wr(6'd32, 16'h0002); wr(6'd0, 16'hFFF5);     // ch0 compare on A
        wr(6'd33, 16'h0006); wr(6'd1, 16'h0102);     // ch1 compare on B
        wr(6'd34, 16'h0002); wr(6'd2, 16'h0102);     // ch2 compare on A, never reached
        wr(6'd44, 16'h0002); wr(6'd12, 16'hFFF5);    // ch12 capture-only
        wr(6'd17, 16'hFFF0); wr(6'd16, 16'hFFF0);
        wr(6'd19, 16'h0100); wr(6'd18, 16'hFFFA);
        wr(6'd20, 16'h0028); wr(6'd21, 16'h0028);
        ca = 16'hFFF0; cb = 16'hFFFA; exp_out = '0; exp_flg = '0;
        for (int s = 0; s < 48; s++) begin
            pulse_ovf();
            ca = (ca == 16'hFFFF) ? 16'hFFF0 : ca + 1'b1;
            cb = (cb == 16'hFFFF) ? 16'h0100 : cb + 1'b1;
            if (ca == 16'hFFF5) begin exp_out[0] = ~exp_out[0]; exp_flg[0] = 1'b1; end
            if (cb == 16'h0102) begin exp_out[1] = ~exp_out[1]; exp_flg[1] = 1'b1; end
            rd(6'd16, d); chk("R2 R4 timer A", d, ca);
            rd(6'd18, d); chk("R2 R4 timer B", d, cb);
            chk("R9 R8 outputs", {4'h0, cc_pin_out}, {4'h0, exp_out});
            chk("R9 R10 flags", irq_flag, exp_flg);
        end

        // R11: write-one-to-clear on a single bit
        wr(6'd24, 16'h0001);
        rd(6'd24, d); chk("R11", d, 16'h0002);
        wr(6'd24, 16'h0000);
        rd(6'd24, d); chk("R11", d, 16'h0002);
        wr(6'd24, 16'hFFFF);
        rd(6'd24, d); chk("R11", d, 16'h0000);

        // R6: run bit clear holds the count despite ticks
        wr(6'd20, 16'h0008);
        pulse_ovf(); pulse_ovf();
        rd(6'd16, d); chk("R6", d, ca);
        wr(6'd21, 16'h0000);

        // R7 R8 R12: capture sweep with timers stopped
        for (int ch = 0; ch < 16; ch++) begin
            logic [1:0] md, eg;
            md = (ch % 4 == 3) ? 2'b00 : 2'b01;
            eg = (ch % 4 == 0) ? 2'b01 : (ch % 4 == 1) ? 2'b10 : 2'b11;
            wr(6'(32 + ch), {11'h0, eg, 1'(ch >> 2), md});
            exp_val[ch] = 16'(ch * 16'h0111);
            wr(6'(ch), exp_val[ch]);
        end
        wr(6'd20, 16'h0000);
        wr(6'd24, 16'hFFFF);
        pat[0] = 16'hFFFF; pat[1] = 16'h0000; pat[2] = 16'hA5A5;
        pat[3] = 16'h5A5A; pat[4] = 16'h0F0F; pat[5] = 16'hFFFF;
        pins_old = '0; exp_flg = '0;
        for (int k = 0; k < 6; k++) begin
            tva = 16'(16'h1000 + k * 16'h0111);
            tvb = 16'(16'h8000 + k * 16'h0222);
            wr(6'd16, tva); wr(6'd18, tvb);
            @(negedge clk) cc_pin_in = pat[k];
            repeat (5) @(negedge clk);
            for (int ch = 0; ch < 16; ch++) begin
                bit r, f, hit;
                r = pat[k][ch] & ~pins_old[ch];
                f = ~pat[k][ch] & pins_old[ch];
                case (ch % 4)
                    0: hit = r;
                    1: hit = f;
                    2: hit = r | f;
                    default: hit = 1'b0;
                endcase
                if (hit) begin
                    exp_val[ch] = ((ch >> 2) & 1) ? tvb : tva;
                    exp_flg[ch] = 1'b1;
                end
                rd(6'(ch), d);
                chk((ch % 4 == 3) ? "R12" : "R7 R8", d, exp_val[ch]);
            end
            chk("R7 flags", irq_flag, exp_flg);
            pins_old = pat[k];
        end

        // R5: count pin drives timer A only
        wr(6'd16, 16'h0000); wr(6'd18, 16'h0005);
        wr(6'd20, 16'h0030); wr(6'd21, 16'h0030);
        for (int p = 0; p < 10; p++) begin
            @(negedge clk) cnt_pin = 1'b1;
            repeat (3) @(negedge clk);
            cnt_pin = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (5) @(negedge clk);
        rd(6'd16, d); chk("R5 timer A", d, 16'd10);
        rd(6'd18, d); chk("R5 timer B", d, 16'd5);
        wr(6'd21, 16'h0000);

        // R3: every prescaler ratio over a 2048-cycle window
        for (int ps = 0; ps < 8; ps++) begin
            wr(6'd16, 16'h0000);
            wr(6'd20, 16'(16'h0020 | ps));
            rd(6'd16, c0);
            repeat (2047) @(negedge clk);
            rd(6'd16, d);
            chk("R3", d - c0, 16'(2048 >> (3 + ps)));
            wr(6'd20, 16'h0000);
        end

        rd(6'd17, ra); chk("R2 reload A", ra, 16'hFFF0);
        rd(6'd19, rb); chk("R2 reload B", rb, 16'h0100);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule